// File: doc/BRIEF.md
# Addressable Bit Register with Demultiplex Mode

This block holds a word of single-bit cells. An address input picks one cell, and a data bit is written into it. Two active-low controls choose one of four operating modes. With enable low and clear high, only the addressed cell is written. With both controls high, every cell holds its value. With both controls low, the block works as a demultiplexer: the addressed output takes the data bit and every other output goes low. With enable high and clear low, every cell is cleared.

The block is a clocked design. All inputs are sampled on the rising clock edge, and the outputs are registered and change on that same edge. A synchronous active-high reset clears the whole word, and it acts separately from the functional clear. With data held high in demultiplex mode, the block works as a one-hot decoder.

Top module: `addr_bit_reg`

## Requirements
- R1: While `rst` is high at a rising edge, every output bit is 0 after that edge, whatever the other inputs are.
- R2: When enable_n=0 and clear_n=1 (write mode), only output bit `addr` takes `din` after the edge. All other bits keep their values.
- R3: When enable_n=1 and clear_n=1 (hold mode), all output bits keep their values, whatever `addr` and `din` are.
- R4: When enable_n=0 and clear_n=0 (demultiplex mode), output bit `addr` takes `din` after the edge and every other bit becomes 0.
- R5: When enable_n=1 and clear_n=0 (clear mode), every output bit becomes 0, whatever `addr` and `din` are.
- R6: The address is unsigned binary with bit 0 as the LSB. Address value n selects output bit n.
- R7: After demultiplex or clear mode, each bit keeps the value it last received. Later write and hold cycles start from those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (3) | Cell select, bit 0 is the LSB |
| din | input | 1 | Data bit |
| enable_n | input | 1 | Active-low enable |
| clear_n | input | 1 | Active-low functional clear |
| q | output | 2**ADDR_W (8) | Registered cell outputs |

## Verification
The bench builds the block with the default ADDR_W=3, which gives eight cells. At this size every address can be visited many times, and all four modes occur often enough to hit every (address, data) pair. Directed sequences set every bit high, then check a single demultiplex write, a clear, and a decoder sweep. After that, random mode, address and data patterns run against a bench model, and all outputs are compared on every cycle.

// File: rtl/abr_pkg.sv
package abr_pkg;
    typedef enum logic [1:0] {
        MODE_DEMUX = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_WRITE = 2'b10,
        MODE_HOLD  = 2'b11
    } abr_mode_e;

    // Mode from the active-low controls: {clear_n, enable_n}
    function automatic abr_mode_e decode_mode(input logic enable_n, input logic clear_n);
        return abr_mode_e'({clear_n, enable_n});
    endfunction
endpackage

// File: rtl/abr_decoder.sv
module abr_decoder #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NBITS-1:0]  sel
);
    for (genvar i = 0; i < NBITS; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/abr_cell.sv
module abr_cell (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             din,
    input  abr_pkg::abr_mode_e mode,
    output logic             q
);
    import abr_pkg::*;
    logic nxt;

    always_comb begin
        unique case (mode)
            MODE_WRITE: nxt = sel ? din : q;
            MODE_HOLD:  nxt = q;
            MODE_DEMUX: nxt = sel & din;
            default:    nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= nxt;
    end
endmodule

// File: rtl/addr_bit_reg.sv
module addr_bit_reg #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    input  logic              enable_n,
    input  logic              clear_n,
    output logic [NBITS-1:0]  q
);
    import abr_pkg::*;
    abr_mode_e          mode;
    logic [NBITS-1:0]   sel;

    assign mode = decode_mode(enable_n, clear_n);

    abr_decoder #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .sel(sel));

    for (genvar i = 0; i < NBITS; i++) begin : g_cell
        abr_cell u_cell (
            .clk(clk), .rst(rst), .sel(sel[i]), .din(din),
            .mode(mode), .q(q[i])
        );
    end
endmodule

// File: rtl/addr_bit_reg_chk.sv
module addr_bit_reg_chk #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              din,
    input logic              enable_n,
    input logic              clear_n,
    input logic [NBITS-1:0]  q
);
    logic [NBITS-1:0] onebit;
    assign onebit = NBITS'(1) << addr;

    p_reset_r1: assert property (@(posedge clk) rst |=> (q == '0));
    p_write_r2: assert property (@(posedge clk) disable iff (rst)
        (!enable_n && clear_n) |=> ((q & ~$past(onebit)) == ($past(q) & ~$past(onebit)))
                                   && (q[$past(addr)] == $past(din)));
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (enable_n && clear_n) |=> $stable(q));
    p_demux_r4: assert property (@(posedge clk) disable iff (rst)
        (!enable_n && !clear_n) |=> (q == ($past(din) ? $past(onebit) : '0)));
    p_demux_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        (!enable_n && !clear_n) |=> $onehot0(q));
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (enable_n && !clear_n) |=> (q == '0));
endmodule

bind addr_bit_reg addr_bit_reg_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .din(din),
    .enable_n(enable_n), .clear_n(clear_n), .q(q)
);

// File: tb/tb_addr_bit_reg.sv
module tb_addr_bit_reg;
    localparam int ADDR_W = 3;
    localparam int NBITS  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              din = 1'b0;
    logic              enable_n = 1'b1;
    logic              clear_n = 1'b1;
    logic [NBITS-1:0]  q;

    int compared = 0;
    int mismatched = 0;
    logic [NBITS-1:0] model = '0;

    always #2.5 clk = ~clk;

    addr_bit_reg #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .addr(addr), .din(din),
        .enable_n(enable_n), .clear_n(clear_n), .q(q)
    );

    function automatic logic [NBITS-1:0] next_word(
        input logic [NBITS-1:0] cur, input logic r, input logic en_n,
        input logic cl_n, input logic [ADDR_W-1:0] a, input logic d);
        logic [NBITS-1:0] w;
        if (r) return '0;
        w = cur;
        case ({cl_n, en_n})
            2'b10: w[a] = d;
            2'b11: w = cur;
            2'b00: begin w = '0; w[a] = d; end
            default: w = '0;
        endcase
        return w;
    endfunction

    task automatic check(input string req);
        compared++;
        if (q !== model) begin
            mismatched++;
            $display("FAIL %s: q=%b expected=%b", req, q, model);
        end
    endtask

    // Apply one cycle: drive at negedge, clock edge, compare at next negedge
    task automatic step(input logic r, input logic en_n, input logic cl_n,
                        input logic [ADDR_W-1:0] a, input logic d, input string req);
        rst = r; enable_n = en_n; clear_n = cl_n; addr = a; din = d;
        model = next_word(model, r, en_n, cl_n, a, d);
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #1000000;
        mismatched++;
        $display("FAIL watchdog: timeout reached, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1, 0, 1, 3'd5, 1, "R1");
        step(1, 0, 0, 3'd2, 1, "R1");
        // R2 / R6: write each address with 1, LSB-first address mapping
        for (int i = 0; i < NBITS; i++) step(0, 0, 1, ADDR_W'(i), 1, "R2 R6");
        step(0, 0, 1, 3'd3, 0, "R2");
        // R3: hold ignores address and data
        step(0, 1, 1, 3'd3, 1, "R3");
        step(0, 1, 1, 3'd0, 0, "R3");
        // R4: demux zeroes others
        step(0, 0, 0, 3'd6, 1, "R4");
        step(0, 1, 1, 3'd1, 0, "R7");
        step(0, 0, 0, 3'd6, 0, "R4");
        // decoder sweep R4 R6
        for (int i = 0; i < NBITS; i++) step(0, 0, 0, ADDR_W'(i), 1, "R4 R6");
        // R7: writes start from demux result
        step(0, 0, 1, 3'd1, 1, "R7");
        step(0, 1, 1, 3'd4, 0, "R7");
        // R5: clear ignores inputs
        for (int i = 0; i < NBITS; i++) step(0, 0, 1, ADDR_W'(i), 1, "R2");
        step(0, 1, 0, 3'd7, 1, "R5");
        step(0, 1, 1, 3'd7, 1, "R7");
        step(0, 0, 1, 3'd2, 1, "R7");
        // random
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] rv;
            rv = $urandom();
            step((rv[15:0] == 16'd7), rv[4], rv[5] | rv[6], rv[ADDR_W+7:8], rv[12], "R2 R3 R4 R5");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule